// File: doc/BRIEF.md
# Supervisory Reset and Fail-Flag Generator

This block turns digitised supply-monitor results into the system reset and two status flags. It takes a primary-supply flag, a secondary-monitor flag, an active-low manual-reset pin and a 2-bit timeout select. It drives a reset in both polarities, an early low-supply warning and a secondary-fail flag. Reset is held while the primary supply is low or manual reset is pressed. Once the cause clears, reset is stretched for a selectable timeout. All timing comes from a slow tick that is divided down from the system clock.

The manual-reset pin is filtered by a debounce stage, so contact bounce and short glitches never reach the reset logic. The early-warning flag and the secondary-fail flag follow their comparator inputs directly, with no stretch.

Top module: `supv_reset_gen`

## Requirements
- R1: `tsel` picks the reset stretch length in ticks: 00 gives TO0_TICKS (50), 01 gives TO1_TICKS (200), 10 gives TO2_TICKS (400), 11 gives TO3_TICKS (800). With the default tick of 1 ms these are 0.05 s, 0.2 s, 0.4 s and 0.8 s.
- R2: While `vpri_ok` is 0, `rst_hi` is 1 from the next clock onward.
- R3: After `vpri_ok` returns to 1, `rst_hi` drops after exactly the selected number of ticks with the supply continuously high. The tick boundary can fall anywhere, so this is between N-1 and N tick periods plus one clock.
- R4: If `vpri_ok` falls during a stretch, the stretch count restarts from zero once the supply is back.
- R5: When the debounced manual reset is pressed (`mr_n` = 0), `rst_hi` is 1. After the debounced release, reset stays asserted for the full selected timeout. `mr_n` = 1 means not pressed, which is what an undriven pin with a pull-up reads.
- R6: A level change on `mr_n` is accepted only after it has been stable for DEB_TICKS (16) consecutive ticks. A pulse shorter than that has no effect on `rst_hi`.
- R7: `lowline_n` equals `vpri_ok` in the same cycle, with no register in the path.
- R8: `sec_fail_n` equals `vsec_ok` in the same cycle and does not depend on the reset state.
- R9: `rst_lo_n` is always the complement of `rst_hi`.
- R10: `tsel` is captured when a stretch begins counting. A change to `tsel` during a running stretch applies only to the next stretch.
- R11: While `rst_n` is low, `rst_hi` is 1. After `rst_n` is released, a full stretch runs before reset drops, even if the supply is already good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| vpri_ok | input | 1 | Primary supply above its trip point |
| vsec_ok | input | 1 | Secondary monitored voltage above its trip point |
| mr_n | input | 1 | Manual reset request, active low |
| tsel | input | 2 | Reset stretch select |
| rst_hi | output | 1 | System reset, active high |
| rst_lo_n | output | 1 | System reset, active low |
| lowline_n | output | 1 | Early low-supply warning, active low |
| sec_fail_n | output | 1 | Secondary supply fail, active low |

## Verification
The two flags are combinational, so the bench checks them a fraction of a clock after it changes the input. Reset assertion on a supply loss takes one clock. Reset release is due N ticks after the cause clears, and the tick phase decides where inside the last tick period it happens. The bench therefore checks that reset is still asserted at N-1 tick periods and released a few clocks after N tick periods. The manual-reset checks add the 2-flop synchroniser and the 16-tick filter to those windows, again with one bound on each side. All sampling is done on the falling clock edge, and inputs also change only on the falling edge.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Timeout select codes
    typedef enum logic [1:0] {
        TSEL_SHORT = 2'b00,
        TSEL_MID   = 2'b01,
        TSEL_LONG  = 2'b10,
        TSEL_MAX   = 2'b11
    } tsel_e;

    // Pick the stretch length in ticks for a select code
    function automatic int unsigned pick_limit(
        input logic [1:0] sel,
        input int unsigned l0,
        input int unsigned l1,
        input int unsigned l2,
        input int unsigned l3
    );
        case (tsel_e'(sel))
            TSEL_SHORT: pick_limit = l0;
            TSEL_MID:   pick_limit = l1;
            TSEL_LONG:  pick_limit = l2;
            default:    pick_limit = l3;
        endcase
    endfunction

endpackage

// File: rtl/supv_tick_gen.sv
module supv_tick_gen #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pulse;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pulse = 1'b0;
        if (s_q.cnt == LAST) begin
            s_d.cnt   = '0;
            s_d.pulse = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.pulse;
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
    parameter int unsigned DEB_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw_n,
    output logic pressed
);
    localparam int unsigned CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          level;
        logic [CW-1:0] run;
    } deb_st_t;

    deb_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sync1 = raw_n;
        s_d.sync2 = s_q.sync1;
        if (s_q.sync2 == s_q.level) begin
            s_d.run = '0;
        end else if (tick) begin
            if (s_q.run == LAST) begin
                s_d.level = s_q.sync2;
                s_d.run   = '0;
            end else begin
                s_d.run = s_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sync1 <= 1'b1;
            s_q.sync2 <= 1'b1;
            s_q.level <= 1'b1;
            s_q.run   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pressed = ~s_q.level;
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
    import supv_pkg::*;
#(
    parameter int unsigned TO0_TICKS = 50,
    parameter int unsigned TO1_TICKS = 200,
    parameter int unsigned TO2_TICKS = 400,
    parameter int unsigned TO3_TICKS = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic [1:0] tsel,
    output logic       active
);
    localparam int unsigned CW = $clog2(TO3_TICKS + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } str_st_t;

    str_st_t s_d, s_q;
    logic [CW-1:0] lim_now;
    logic [CW-1:0] lim_use;

    always_comb begin
        lim_now = CW'(pick_limit(tsel, TO0_TICKS, TO1_TICKS, TO2_TICKS, TO3_TICKS));
        // select is frozen once the first tick of a stretch has been counted
        lim_use = (s_q.cnt == '0) ? lim_now : s_q.lim;
        s_d = s_q;
        s_d.lim = lim_use;
        if (hold) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
        end else if (s_q.active && tick) begin
            if (s_q.cnt == lim_use - 1'b1) begin
                s_d.active = 1'b0;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.active <= 1'b1;
            s_q.cnt    <= '0;
            s_q.lim    <= CW'(TO3_TICKS);
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.active;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
    parameter int unsigned TICK_DIV  = 50000,
    parameter int unsigned DEB_TICKS = 16,
    parameter int unsigned TO0_TICKS = 50,
    parameter int unsigned TO1_TICKS = 200,
    parameter int unsigned TO2_TICKS = 400,
    parameter int unsigned TO3_TICKS = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vpri_ok,
    input  logic       vsec_ok,
    input  logic       mr_n,
    input  logic [1:0] tsel,
    output logic       rst_hi,
    output logic       rst_lo_n,
    output logic       lowline_n,
    output logic       sec_fail_n
);
    logic tick;
    logic mr_pressed;
    logic hold;
    logic stretch_on;

    supv_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    supv_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .raw_n   (mr_n),
        .pressed (mr_pressed)
    );

    supv_stretch #(
        .TO0_TICKS(TO0_TICKS),
        .TO1_TICKS(TO1_TICKS),
        .TO2_TICKS(TO2_TICKS),
        .TO3_TICKS(TO3_TICKS)
    ) u_str (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .hold   (hold),
        .tsel   (tsel),
        .active (stretch_on)
    );

    always_comb begin
        hold       = ~vpri_ok | mr_pressed;
        rst_hi     = stretch_on;
        rst_lo_n   = ~stretch_on;
        lowline_n  = vpri_ok;
        sec_fail_n = vsec_ok;
    end
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
    parameter int unsigned TICK_DIV  = 50000,
    parameter int unsigned TO0_TICKS = 50
) (
    input logic clk,
    input logic rst_n,
    input logic vpri_ok,
    input logic vsec_ok,
    input logic rst_hi,
    input logic rst_lo_n,
    input logic lowline_n,
    input logic sec_fail_n
);
    localparam int unsigned MIN_UP = (TO0_TICKS - 1) * TICK_DIV;

    // cycles since the primary supply was last seen low, saturating
    int unsigned up_cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                up_cyc <= 0;
        else if (!vpri_ok)         up_cyc <= 0;
        else if (up_cyc < MIN_UP)  up_cyc <= up_cyc + 1;
    end

    // R9
    polarity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lo_n == !rst_hi);

    // R2
    low_supply_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vpri_ok |=> rst_hi);

    // R3
    min_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_hi) |-> (up_cyc >= MIN_UP));

    // R7
    lowline_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowline_n == vpri_ok);

    // R8
    sec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_fail_n == vsec_ok);
endmodule

bind supv_reset_gen supv_reset_gen_chk #(
    .TICK_DIV  (TICK_DIV),
    .TO0_TICKS (TO0_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vpri_ok    (vpri_ok),
    .vsec_ok    (vsec_ok),
    .rst_hi     (rst_hi),
    .rst_lo_n   (rst_lo_n),
    .lowline_n  (lowline_n),
    .sec_fail_n (sec_fail_n)
);

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;
    localparam int TD  = 4;
    localparam int DEB = 16;
    localparam int L0 = 50, L1 = 200, L2 = 400, L3 = 800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vpri_ok = 1'b1;
    logic vsec_ok = 1'b1;
    logic mr_n = 1'b1;
    logic [1:0] tsel = 2'b00;
    logic rst_hi, rst_lo_n, lowline_n, sec_fail_n;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    supv_reset_gen #(
        .TICK_DIV(TD), .DEB_TICKS(DEB),
        .TO0_TICKS(L0), .TO1_TICKS(L1), .TO2_TICKS(L2), .TO3_TICKS(L3)
    ) u_supv_reset_gen (
        .clk(clk), .rst_n(rst_n), .vpri_ok(vpri_ok), .vsec_ok(vsec_ok),
        .mr_n(mr_n), .tsel(tsel), .rst_hi(rst_hi), .rst_lo_n(rst_lo_n),
        .lowline_n(lowline_n), .sec_fail_n(sec_fail_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reset output is checked together with its complement (R9)
    task automatic check_rst(input logic exp, input string tag);
        check(rst_hi, exp, tag);
        check(rst_lo_n, ~exp, {tag, " R9"});
    endtask

    task automatic t_reset_state;
        wait_n(3);
        check_rst(1'b1, "R11 held in block reset");
        rst_n = 1'b1;
        wait_n((L0 - 1) * TD - 2);
        check_rst(1'b1, "R11 stretch after block reset");
        wait_n(8);
        check_rst(1'b0, "R11 released after stretch");
    endtask

    task automatic t_timeout(input logic [1:0] sel, input int lim);
        tsel = sel;
        vpri_ok = 1'b0;
        wait_n(5);
        check_rst(1'b1, "R2 supply low");
        vpri_ok = 1'b1;
        wait_n((lim - 1) * TD);
        check_rst(1'b1, "R1 R3 before timeout");
        wait_n(6);
        check_rst(1'b0, "R1 R3 after timeout");
    endtask

    task automatic t_restart;
        tsel = 2'b00;
        vpri_ok = 1'b0;
        wait_n(5);
        vpri_ok = 1'b1;
        wait_n(30 * TD);
        vpri_ok = 1'b0;
        wait_n(3);
        check_rst(1'b1, "R4 dip during stretch");
        vpri_ok = 1'b1;
        wait_n((L0 - 1) * TD);
        check_rst(1'b1, "R4 count restarted");
        wait_n(6);
        check_rst(1'b0, "R4 release after full restart");
    endtask

    task automatic t_manual;
        tsel = 2'b00;
        mr_n = 1'b0;
        wait_n(10 * TD);
        check_rst(1'b0, "R6 short press ignored");
        mr_n = 1'b1;
        wait_n(20 * TD);
        check_rst(1'b0, "R6 after glitch");
        mr_n = 1'b0;
        wait_n(DEB * TD + 8);
        check_rst(1'b1, "R5 press accepted");
        wait_n(20 * TD);
        check_rst(1'b1, "R5 held while pressed");
        mr_n = 1'b1;
        wait_n((DEB - 1) * TD + (L0 - 1) * TD);
        check_rst(1'b1, "R5 stretch after release");
        wait_n(16);
        check_rst(1'b0, "R5 released after stretch");
    endtask

    task automatic t_flags;
        vpri_ok = 1'b0;
        #1;
        check(lowline_n, 1'b0, "R7 lowline low");
        wait_n(2);
        vpri_ok = 1'b1;
        #1;
        check(lowline_n, 1'b1, "R7 lowline high");
        vsec_ok = 1'b0;
        #1;
        check(sec_fail_n, 1'b0, "R8 sec fail low");
        check(rst_hi, 1'b1, "R8 reset state unchanged");
        vsec_ok = 1'b1;
        #1;
        check(sec_fail_n, 1'b1, "R8 sec fail high");
        wait_n(L0 * TD + 6);
        check_rst(1'b0, "R7 settle");
        vsec_ok = 1'b0;
        #1;
        check(sec_fail_n, 1'b0, "R8 sec fail with reset idle");
        check(rst_hi, 1'b0, "R8 no reset from secondary");
        vsec_ok = 1'b1;
        wait_n(1);
    endtask

    task automatic t_sel_change;
        tsel = 2'b00;
        vpri_ok = 1'b0;
        wait_n(5);
        vpri_ok = 1'b1;
        wait_n(10 * TD);
        tsel = 2'b11;
        wait_n((L0 - 10) * TD + 6);
        check_rst(1'b0, "R10 old select kept");
        vpri_ok = 1'b0;
        wait_n(5);
        vpri_ok = 1'b1;
        wait_n(60 * TD);
        check_rst(1'b1, "R10 new select used next");
        wait_n((L3 - 1 - 60) * TD);
        check_rst(1'b1, "R10 before long timeout");
        wait_n(6);
        check_rst(1'b0, "R10 after long timeout");
        tsel = 2'b00;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_timeout(2'b00, L0);
        t_timeout(2'b01, L1);
        t_timeout(2'b10, L2);
        t_timeout(2'b11, L3);
        t_restart();
        t_manual();
        t_flags();
        t_sel_change();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end
endmodule